// File: doc/BRIEF.md
# Programmable-Resolution Watchdog Timer

This block is a watchdog built around a 20-bit down-counter. Its tick period is chosen by software from a 4-bit power-of-two resolution code. The tick comes from a 32.768 kHz timebase, which the block derives from its own clock through a fixed divider. Software sees two 32-bit registers. A control register at byte offset 0 holds the timeout in ticks, the resolution, a run bit, a reset-arm bit and a hardware load-busy flag. A read-only register at byte offset 4 shows the ticks that remain.

Any write to the control register starts a short, fixed-length load step. For those cycles the busy flag reads as one and the remaining-count register keeps its old value. When the step ends, the counter takes the written timeout and both tick dividers restart. Rewriting the control register while the timer runs is the keepalive. When the counter reaches zero with the reset-arm bit set, the block raises a reset request that stays high until the block itself is reset. With the arm bit clear, the counter stops at zero and waits for a new write.

The sequencer has five states:
- `ST_IDLE`: loaded but not counting.
- `ST_SYNC`: load step in progress.
- `ST_RUN`: counting down.
- `ST_HOLD`: stopped at zero with no reset.
- `ST_TRIP`: reset request raised.

Its transitions:
- A control write in IDLE, RUN or HOLD goes to SYNC. A further write during SYNC restarts the step.
- SYNC, after `LOAD_CYCLES` cycles, goes to RUN if the run bit is set and to IDLE if it is clear.
- RUN, once the count is zero, goes to TRIP if the arm bit is set and to HOLD if it is clear.
- TRIP is left only by reset.

Top module: `tickdog`

## Requirements
- R1: After reset, offset 0 reads 0x00400000 (resolution code 4 in bits [23:20], every other bit zero), offset 4 reads 0, and `rst_req` is low.
- R2: A write to offset 0 stores the timeout from bits [19:0], the resolution from bits [23:20], the reset-arm bit from bit 26 and the run bit from bit 27. Once the load step is over, offset 0 reads these fields back in the same positions.
- R3: Bits 31:29, 25 and 24 of offset 0 always read zero. Bit 28 cannot be written. A write to offset 4 changes nothing. Offsets other than 0 and 4 read zero.
- R4: After the clock edge that takes a write to offset 0, bit 28 of offset 0 reads 1 for exactly `LOAD_CYCLES` cycles (3 by default). During those cycles offset 4 keeps its old value. In the next cycle bit 28 reads 0 and offset 4 holds the written timeout.
- R5: With the run bit set, the count at offset 4 falls by exactly one every `CLK_PER_TB * 2^(15 - resolution)` clock cycles.
- R6: With the run bit clear, the loaded count does not change.
- R7: Rewriting offset 0 while the timer runs reloads the counter with the new timeout (keepalive).
- R8: When the count reaches zero with the reset-arm bit set, `rst_req` goes high. It stays high, and the count stays at zero, through any later register write, until `rst_n` is asserted.
- R9: When the count reaches zero with the reset-arm bit clear, the count stays at zero and `rst_req` stays low. A later write loads a new timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rst_req | output | 1 | Sticky reset request raised on expiry |

## Verification
The bench sets `CLK_PER_TB` to 2, so one timebase period is two clocks. This makes the finest resolutions tick every few cycles, and it brings the reset-default code 4 (4096 cycles per tick) into range of a short run. `LOAD_CYCLES` stays at 3, which lets the bench check the busy window one cycle at a time. Expiry with and without a reset request is reached by loading timeouts of a few ticks at resolution 15.

// File: rtl/tickdog_pkg.sv
package tickdog_pkg;

    localparam int DATA_W    = 32;
    localparam int RES_LSB   = 20;
    localparam int BIT_RSTEN = 26;
    localparam int BIT_RUN   = 27;
    localparam int BIT_BUSY  = 28;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_LEFT  = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SYNC = 3'd1,
        ST_RUN  = 3'd2,
        ST_HOLD = 3'd3,
        ST_TRIP = 3'd4
    } wd_state_e;

endpackage

// File: rtl/tickdog_timebase.sv
module tickdog_timebase #(
    parameter int CLK_PER_TB = 1000,
    parameter int RES_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [RES_W-1:0] res,
    output logic             tick
);
    localparam int MAX_RES = (1 << RES_W) - 1;
    localparam int PRE_W   = MAX_RES + 1;

    logic             tb_pulse;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_last;

    generate
        if (CLK_PER_TB > 1) begin : g_div
            localparam int TBW = $clog2(CLK_PER_TB);
            localparam logic [TBW-1:0] TB_LAST = TBW'(CLK_PER_TB - 1);
            logic [TBW-1:0] tb_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tb_cnt <= '0;
                end else if (restart || tb_cnt == TB_LAST) begin
                    tb_cnt <= '0;
                end else begin
                    tb_cnt <= tb_cnt + 1'b1;
                end
            end
            assign tb_pulse = (tb_cnt == TB_LAST);
        end else begin : g_nodiv
            assign tb_pulse = 1'b1;
        end
    endgenerate

    // timebase pulses per tick minus one: 2^(MAX_RES - res) - 1
    assign pre_last = (PRE_W'(1) << (RES_W'(MAX_RES) - res)) - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (restart) begin
            pre_cnt <= '0;
        end else if (tb_pulse) begin
            pre_cnt <= (pre_cnt == pre_last) ? '0 : pre_cnt + 1'b1;
        end
    end

    assign tick = !restart && tb_pulse && (pre_cnt == pre_last);

endmodule

// File: rtl/tickdog_regs.sv
module tickdog_regs
    import tickdog_pkg::*;
#(
    parameter int               CNT_W     = 20,
    parameter int               RES_W     = 4,
    parameter int               ADDR_W    = 4,
    parameter logic [RES_W-1:0] RES_RESET = 4'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic [CNT_W-1:0]  cur_count,
    output logic              ctrl_wr,
    output logic [CNT_W-1:0]  ctl_count,
    output logic [RES_W-1:0]  ctl_res,
    output logic              ctl_run,
    output logic              ctl_rst_en,
    output logic [DATA_W-1:0] reg_rdata
);
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_count  <= '0;
            ctl_res    <= RES_RESET;
            ctl_run    <= 1'b0;
            ctl_rst_en <= 1'b0;
        end else if (ctrl_wr) begin
            ctl_count  <= reg_wdata[CNT_W-1:0];
            ctl_res    <= reg_wdata[RES_LSB +: RES_W];
            ctl_run    <= reg_wdata[BIT_RUN];
            ctl_rst_en <= reg_wdata[BIT_RSTEN];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTRL)) begin
            reg_rdata[CNT_W-1:0]         = ctl_count;
            reg_rdata[RES_LSB +: RES_W]  = ctl_res;
            reg_rdata[BIT_RSTEN]         = ctl_rst_en;
            reg_rdata[BIT_RUN]           = ctl_run;
            reg_rdata[BIT_BUSY]          = busy;
        end else if (reg_addr == ADDR_W'(OFS_LEFT)) begin
            reg_rdata[CNT_W-1:0]         = cur_count;
        end
    end

endmodule

// File: rtl/tickdog_seq.sv
module tickdog_seq
    import tickdog_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int LOAD_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] ctl_count,
    input  logic             ctl_run,
    input  logic             ctl_rst_en,
    input  logic             tick,
    output logic             load,
    output logic             busy,
    output logic             trip,
    output logic [CNT_W-1:0] cur_count
);
    localparam int SW = (LOAD_CYCLES > 1) ? $clog2(LOAD_CYCLES) : 1;
    localparam logic [SW-1:0] SYNC_LAST = SW'(LOAD_CYCLES - 1);

    wd_state_e       state, state_nx;
    logic [SW-1:0]   sync_cnt;

    assign load = (state == ST_SYNC) && !ctrl_wr && (sync_cnt == SYNC_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_HOLD: begin
                if (ctrl_wr) state_nx = ST_SYNC;
            end
            ST_RUN: begin
                if (ctrl_wr)                state_nx = ST_SYNC;
                else if (cur_count == '0)   state_nx = ctl_rst_en ? ST_TRIP : ST_HOLD;
            end
            ST_SYNC: begin
                if (load) state_nx = ctl_run ? ST_RUN : ST_IDLE;
            end
            ST_TRIP: begin
                state_nx = ST_TRIP;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_cnt <= '0;
        end else if (ctrl_wr && state != ST_TRIP) begin
            sync_cnt <= '0;
        end else if (state == ST_SYNC) begin
            sync_cnt <= sync_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_count <= '0;
        end else if (load) begin
            cur_count <= ctl_count;
        end else if (state == ST_RUN && !ctrl_wr && tick && cur_count != '0) begin
            cur_count <= cur_count - 1'b1;
        end
    end

    always_comb begin
        busy = (state == ST_SYNC);
        trip = (state == ST_TRIP);
    end

endmodule

// File: rtl/tickdog.sv
module tickdog
    import tickdog_pkg::*;
#(
    parameter int CLK_PER_TB  = 1000,
    parameter int CNT_W       = 20,
    parameter int RES_W       = 4,
    parameter int ADDR_W      = 4,
    parameter int LOAD_CYCLES = 3,
    parameter int RES_RESET   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rst_req
);
    logic             ctrl_wr;
    logic [CNT_W-1:0] ctl_count;
    logic [RES_W-1:0] ctl_res;
    logic             ctl_run;
    logic             ctl_rst_en;
    logic             load;
    logic             busy;
    logic             tick;
    logic [CNT_W-1:0] cur_count;

    tickdog_regs #(
        .CNT_W     (CNT_W),
        .RES_W     (RES_W),
        .ADDR_W    (ADDR_W),
        .RES_RESET (RES_W'(RES_RESET))
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .cur_count  (cur_count),
        .ctrl_wr    (ctrl_wr),
        .ctl_count  (ctl_count),
        .ctl_res    (ctl_res),
        .ctl_run    (ctl_run),
        .ctl_rst_en (ctl_rst_en),
        .reg_rdata  (reg_rdata)
    );

    tickdog_timebase #(
        .CLK_PER_TB (CLK_PER_TB),
        .RES_W      (RES_W)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .res     (ctl_res),
        .tick    (tick)
    );

    tickdog_seq #(
        .CNT_W       (CNT_W),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctl_count  (ctl_count),
        .ctl_run    (ctl_run),
        .ctl_rst_en (ctl_rst_en),
        .tick       (tick),
        .load       (load),
        .busy       (busy),
        .trip       (rst_req),
        .cur_count  (cur_count)
    );

endmodule

// File: rtl/tickdog_chk.sv
module tickdog_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [CNT_W-1:0] cur_count,
    input logic             rst_req
);
    // R8: the reset request never drops while rst_n is high
    p_sticky_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R8: a raised reset request always goes with a zero count
    p_trip_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cur_count == '0));

    // R4: the visible count does not move while the load step runs
    p_hold_during_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(cur_count));

    // R5: the count changes only by a single decrement or at the end of a load step
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count != $past(cur_count)) |->
            (($past(busy) && !busy) || (cur_count == CNT_W'($past(cur_count) - 1'b1))));

endmodule

bind tickdog tickdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cur_count (cur_count),
    .rst_req   (rst_req)
);

// File: tb/tickdog_bench.sv
`timescale 1ns/100ps
module tickdog_bench;

    localparam int CLK_PER_TB  = 2;
    localparam int LOAD_CYCLES = 3;
    localparam int ADDR_W      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              rst_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    tickdog #(
        .CLK_PER_TB  (CLK_PER_TB),
        .ADDR_W      (ADDR_W),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_tickdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rst_req   (rst_req)
    );

    function automatic logic [31:0] ctrl_word(input bit run, input bit arm,
                                              input int res, input int cnt);
        return (32'(run) << 27) | (32'(arm) << 26) | (32'(res & 15) << 20) | 32'(cnt & 20'hFFFFF);
    endfunction

    function automatic int tick_period(input int res);
        return CLK_PER_TB << (15 - res);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output logic [31:0] val);
        reg_addr = ADDR_W'(addr);
        #0.5;
        val = reg_rdata;
    endtask

    // drive at a falling edge, returns at the first falling edge after the capturing edge
    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_addr  = ADDR_W'(addr);
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wr_and_settle(input logic [31:0] data);
        wr(0, data);
        repeat (LOAD_CYCLES) @(negedge clk);
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        @(negedge clk);
        rd(0, v); check("R1 ctrl reset", v, 32'h0040_0000);
        rd(4, v); check("R1 count reset", v, 32'h0);
        check("R1 rst_req reset", 32'(rst_req), 32'h0);
    endtask

    task automatic t_masking;
        logic [31:0] v;
        wr_and_settle(32'hF3FF_FFFF);
        rd(0, v); check("R3 reserved bits read zero", v, 32'h00FF_FFFF);
        rd(4, v); check("R3 count loaded", v, 32'h000F_FFFF);
        wr(4, 32'h0000_0123);
        rd(0, v); check("R3 offset4 write no busy", v, 32'h00FF_FFFF);
        repeat (4) @(negedge clk);
        rd(4, v); check("R3 offset4 write ignored", v, 32'h000F_FFFF);
        rd(8, v); check("R3 unused offset reads zero", v, 32'h0);
        repeat (50) @(negedge clk);
        rd(4, v); check("R6 stopped count holds", v, 32'h000F_FFFF);
    endtask

    task automatic t_load_window;
        logic [31:0] v;
        wr_and_settle(ctrl_word(0, 0, 15, 20'h12345));
        wr(0, ctrl_word(0, 0, 15, 20'h00ABC));
        for (int i = 0; i < LOAD_CYCLES; i++) begin
            rd(0, v); check("R4 busy set in window", 32'(v[28]), 32'h1);
            rd(4, v); check("R4 old count kept", v, 32'h12345);
            @(negedge clk);
        end
        rd(0, v); check("R4 busy cleared", 32'(v[28]), 32'h0);
        rd(4, v); check("R4 new count shown", v, 32'h00ABC);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr_and_settle(ctrl_word(1, 1, 7, 20'h12345));
        rd(0, v); check("R2 field readback", v, 32'h0C71_2345);
    endtask

    task automatic t_period(input int res);
        logic [31:0] v, prev;
        int c;
        wr_and_settle(ctrl_word(1, 0, res, 1000));
        rd(4, prev);
        c = 0;
        do begin @(negedge clk); rd(4, v); c++; end while (v == prev && c < 3 * tick_period(res));
        prev = v;
        c = 0;
        do begin @(negedge clk); rd(4, v); c++; end while (v == prev && c < 3 * tick_period(res));
        check($sformatf("R5 period at resolution %0d", res), 32'(c), 32'(tick_period(res)));
        check($sformatf("R5 step size at resolution %0d", res), v, prev - 1);
    endtask

    task automatic t_keepalive;
        logic [31:0] v;
        wr_and_settle(ctrl_word(1, 1, 15, 10));
        repeat (7) @(negedge clk);
        wr_and_settle(ctrl_word(1, 1, 15, 10));
        rd(4, v); check("R7 keepalive reload", v, 32'd10);
        check("R7 no reset after keepalive", 32'(rst_req), 32'h0);
    endtask

    task automatic t_hold_zero;
        logic [31:0] v;
        wr_and_settle(ctrl_word(1, 0, 15, 2));
        repeat (40) @(negedge clk);
        rd(4, v); check("R9 held at zero", v, 32'h0);
        check("R9 no reset request", 32'(rst_req), 32'h0);
        wr_and_settle(ctrl_word(0, 0, 15, 5));
        rd(4, v); check("R9 reload after hold", v, 32'd5);
    endtask

    task automatic t_trip;
        logic [31:0] v;
        int c;
        wr_and_settle(ctrl_word(1, 1, 15, 3));
        c = 0;
        while (!rst_req && c < 100) begin @(negedge clk); c++; end
        check("R8 reset request raised", 32'(rst_req), 32'h1);
        rd(4, v); check("R8 count zero at trip", v, 32'h0);
        wr(0, ctrl_word(1, 1, 15, 50));
        repeat (10) @(negedge clk);
        check("R8 request sticky over write", 32'(rst_req), 32'h1);
        rd(4, v); check("R8 count stays zero", v, 32'h0);
        rst_n = 1'b0;
        #1;
        check("R8 cleared by reset", 32'(rst_req), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_masking();
        t_load_window();
        t_readback();
        t_period(15);
        t_period(14);
        t_period(12);
        t_period(4);
        t_keepalive();
        t_hold_zero();
        t_trip();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule